// File: doc/BRIEF.md
# Instruction-Field ALU with Branch Condition Unit

This combinational block is the arithmetic and logic unit of a small integer core. Its operation code is the 3-bit function field taken straight from the instruction word, with no extra decode. The register-register and register-immediate instruction forms use the same function values, so the same operation is applied to either form. One more instruction bit, the modifier (bit 30), picks between the two variants where a variant exists. A separate flag tells the block whether the instruction is the register-register form. Only that form may turn an addition into a subtraction.

With the branch select input raised, the block does not return a data result. It subtracts the second operand from the first and derives three flags from the result: equal, signed below and unsigned below. The function field then picks one flag and whether to invert it, and the outcome drives a single taken output. The same subtractor and flags also serve the two set-if-below operations. Operand selection, next-PC arithmetic and multiply/divide are handled elsewhere.

Top module: `funct3_alu`

## Requirements
- R1: In data mode, function code 000 returns the sum of A and B modulo 2^32. A carry or signed overflow out of the top bit is dropped and has no other effect.
- R2: In data mode, function code 000 returns A minus B modulo 2^32 only when the modifier is 1 and the register-register flag is 1. With the register-register flag at 0 it adds, whatever the modifier.
- R3: In data mode, function code 010 returns 1 when A is below B as two's complement signed values, and 0 otherwise.
- R4: In data mode, function code 011 returns 1 when A is below B as unsigned values, and 0 otherwise.
- R5: In data mode, function codes 100, 110 and 111 return the bitwise XOR, OR and AND of A and B.
- R6: In data mode, function code 001 shifts A left and fills the vacated bits with zeros. The shift amount is B[4:0], and the higher bits of B have no effect.
- R7: In data mode, function code 101 shifts A right by B[4:0]. The vacated bits are filled with zeros when the modifier is 0 and with A[31] when the modifier is 1.
- R8: In branch mode, taken reports the condition selected by the function code: 000 A equals B, 001 A differs from B, 100 signed A < B, 101 signed A >= B, 110 unsigned A < B, 111 unsigned A >= B.
- R9: In branch mode, the reserved function codes 010 and 011 give taken = 0.
- R10: In data mode, taken is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register or sign-extended immediate) |
| fn_code | input | 3 | Function field of the instruction |
| fn_mod | input | 1 | Modifier (instruction bit 30) |
| reg_form | input | 1 | 1 for the register-register form |
| branch_sel | input | 1 | 1 to evaluate a branch condition instead of a data result |
| result | output | 32 | Data result (don't care in branch mode) |
| taken | output | 1 | Branch condition outcome |

## Verification
The in-RTL checks are evaluated in the same cycle as the inputs change. They assume every input is a defined 0 or 1 whenever it is sampled. The bench drives all inputs together from one task and lets them settle for half a clock period before reading any output. In branch mode the data result is never checked, and the stimulus never relies on it. Random operands are skewed toward equal values, sign-boundary values and B values with high bits set, so that the equality flag, the signed/unsigned split and the shift-amount masking are all exercised.

// File: rtl/funct3_alu_pkg.sv
package funct3_alu_pkg;
   typedef enum logic [2:0] {
      FN_ADD  = 3'b000,
      FN_SLL  = 3'b001,
      FN_SLT  = 3'b010,
      FN_SLTU = 3'b011,
      FN_XOR  = 3'b100,
      FN_SR   = 3'b101,
      FN_OR   = 3'b110,
      FN_AND  = 3'b111
   } data_fn_e;

   typedef enum logic [1:0] {
      CND_EQ   = 2'b00,
      CND_RSVD = 2'b01,
      CND_LT   = 2'b10,
      CND_LTU  = 2'b11
   } cond_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            sub,
   output logic [XLEN-1:0] sum,
   output logic            flag_zero,
   output logic            flag_lt,
   output logic            flag_ltu
);
   localparam int MSB = XLEN - 1;

   logic [XLEN:0]   wide;
   logic [XLEN-1:0] b_eff;
   logic            ovf;

   assign b_eff     = b ^ {XLEN{sub}};
   assign wide      = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
   assign sum       = wide[MSB:0];
   assign ovf       = (a[MSB] ^ b[MSB]) & (sum[MSB] ^ a[MSB]);
   assign flag_zero = (sum == '0);
   assign flag_lt   = sum[MSB] ^ ovf;
   assign flag_ltu  = ~wide[XLEN];

   always_comb begin
      if (sub) begin
         p_zero_means_equal_r8: assert (flag_zero == (a == b))
            else $error("zero flag disagrees with operand equality");
         p_ltu_matches_compare_r4: assert (flag_ltu == (a < b))
            else $error("unsigned-below flag disagrees with compare");
      end
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int XLEN        = 32,
   parameter bit BARREL_IMPL = 1'b1,
   localparam int SHW        = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] din,
   input  logic [SHW-1:0]  amount,
   input  logic            left,
   input  logic            arith,
   output logic [XLEN-1:0] dout
);
   generate
      if (BARREL_IMPL) begin : g_barrel
         logic [XLEN-1:0] stage [0:SHW];
         logic [XLEN-1:0] flip_in;
         logic [XLEN-1:0] flip_out;
         logic            fill;

         always_comb begin
            for (int i = 0; i < XLEN; i++) flip_in[i] = din[XLEN-1-i];
         end

         assign fill     = arith & ~left & din[XLEN-1];
         assign stage[0] = left ? flip_in : din;

         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stage[s+1] = amount[s]
               ? {{STEP{fill}}, stage[s][XLEN-1:STEP]}
               : stage[s];
         end

         always_comb begin
            for (int i = 0; i < XLEN; i++) flip_out[i] = stage[SHW][XLEN-1-i];
         end

         assign dout = left ? flip_out : stage[SHW];
      end else begin : g_operator
         always_comb begin
            if (left)       dout = din << amount;
            else if (arith) dout = XLEN'($signed(din) >>> amount);
            else            dout = din >> amount;
         end
      end
   endgenerate

   always_comb begin
      if (amount == '0) begin
         p_zero_shift_identity_r6: assert (dout == din)
            else $error("shift by zero altered the operand");
      end
   end
endmodule

// File: rtl/alu_branch_cond.sv
module alu_branch_cond
   import funct3_alu_pkg::*;
(
   input  logic       enable,
   input  logic [2:0] fn_code,
   input  logic       flag_zero,
   input  logic       flag_lt,
   input  logic       flag_ltu,
   output logic       taken
);
   cond_sel_e sel;
   logic      raw;

   assign sel = cond_sel_e'(fn_code[2:1]);

   always_comb begin
      unique case (sel)
         CND_EQ:   raw = flag_zero;
         CND_LT:   raw = flag_lt;
         CND_LTU:  raw = flag_ltu;
         default:  raw = 1'b0;
      endcase
   end

   assign taken = enable & (sel != CND_RSVD) & (raw ^ fn_code[0]);
endmodule

// File: rtl/funct3_alu.sv
module funct3_alu
   import funct3_alu_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter bit BARREL_IMPL = 1'b1
) (
   input  logic [31:0] op_a,
   input  logic [31:0] op_b,
   input  logic [2:0]  fn_code,
   input  logic        fn_mod,
   input  logic        reg_form,
   input  logic        branch_sel,
   output logic [31:0] result,
   output logic        taken
);
   localparam int SHW = $clog2(XLEN);

   generate
      if (XLEN != 32) begin : g_bad_width
         $error("funct3_alu: port widths require XLEN == 32");
      end
      if ((1 << SHW) != XLEN) begin : g_bad_pow2
         $error("funct3_alu: XLEN must be a power of two");
      end
   endgenerate

   data_fn_e        fn;
   logic            do_sub;
   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] shifted;
   logic            f_zero, f_lt, f_ltu;

   assign fn     = data_fn_e'(fn_code);
   assign do_sub = branch_sel | (fn == FN_SLT) | (fn == FN_SLTU)
                 | ((fn == FN_ADD) & fn_mod & reg_form);

   alu_addsub #(.XLEN(XLEN)) u_addsub (
      .a(op_a), .b(op_b), .sub(do_sub), .sum(sum),
      .flag_zero(f_zero), .flag_lt(f_lt), .flag_ltu(f_ltu)
   );

   alu_shifter #(.XLEN(XLEN), .BARREL_IMPL(BARREL_IMPL)) u_shift (
      .din(op_a), .amount(op_b[SHW-1:0]), .left(fn == FN_SLL),
      .arith(fn_mod), .dout(shifted)
   );

   alu_branch_cond u_cond (
      .enable(branch_sel), .fn_code(fn_code), .flag_zero(f_zero),
      .flag_lt(f_lt), .flag_ltu(f_ltu), .taken(taken)
   );

   always_comb begin
      unique case (fn)
         FN_ADD:  result = sum;
         FN_SLL:  result = shifted;
         FN_SLT:  result = {{(XLEN-1){1'b0}}, f_lt};
         FN_SLTU: result = {{(XLEN-1){1'b0}}, f_ltu};
         FN_XOR:  result = op_a ^ op_b;
         FN_SR:   result = shifted;
         FN_OR:   result = op_a | op_b;
         default: result = op_a & op_b;
      endcase
   end

   always_comb begin
      if (!branch_sel) begin
         p_idle_not_taken_r10: assert (!taken)
            else $error("taken raised outside branch mode");
      end
      if (branch_sel && fn_code[2:1] == 2'b01) begin
         p_reserved_not_taken_r9: assert (!taken)
            else $error("reserved branch code reported taken");
      end
      if (branch_sel && fn_code == 3'b000) begin
         p_beq_equal_r8: assert (taken == (op_a == op_b))
            else $error("equal branch disagrees with operands");
      end
      if (!branch_sel && fn_code[2:1] == 2'b01) begin
         p_set_single_bit_r3: assert (result[XLEN-1:1] == '0)
            else $error("set-if-below produced upper bits");
      end
   end
endmodule

// File: tb/funct3_alu_test.sv
module funct3_alu_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [2:0]  fn_code = '0;
   logic        fn_mod = 1'b0, reg_form = 1'b0, branch_sel = 1'b0;
   logic [31:0] result;
   logic        taken;
   int          n_checks = 0;
   int          n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   funct3_alu uut (
      .op_a(op_a), .op_b(op_b), .fn_code(fn_code), .fn_mod(fn_mod),
      .reg_form(reg_form), .branch_sel(branch_sel),
      .result(result), .taken(taken)
   );

   function automatic logic [31:0] model_result(logic [31:0] a, logic [31:0] b,
         logic [2:0] f, logic m, logic r);
      case (f)
         3'b000: return (m && r) ? a - b : a + b;
         3'b001: return a << b[4:0];
         3'b010: return {31'd0, $signed(a) < $signed(b)};
         3'b011: return {31'd0, a < b};
         3'b100: return a ^ b;
         3'b101: return m ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
         3'b110: return a | b;
         default: return a & b;
      endcase
   endfunction

   function automatic logic model_taken(logic [31:0] a, logic [31:0] b, logic [2:0] f);
      case (f)
         3'b000: return a == b;
         3'b001: return a != b;
         3'b100: return $signed(a) < $signed(b);
         3'b101: return $signed(a) >= $signed(b);
         3'b110: return a < b;
         3'b111: return a >= b;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string data_tag(logic [2:0] f, logic m, logic r);
      case (f)
         3'b000: return (m && r) ? "R2" : "R1";
         3'b001: return "R6";
         3'b010: return "R3";
         3'b011: return "R4";
         3'b101: return "R7";
         default: return "R5";
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] f,
         logic m, logic r, logic br);
      @(posedge clk);
      op_a = a; op_b = b; fn_code = f; fn_mod = m; reg_form = r; branch_sel = br;
      @(negedge clk);
      if (br) begin
         check((f[2:1] == 2'b01) ? "R9" : "R8", {31'd0, taken}, {31'd0, model_taken(a, b, f)});
      end else begin
         check(data_tag(f, m, r), result, model_result(a, b, f, m, r));
         check("R10", {31'd0, taken}, 32'd0);
      end
   endtask

   function automatic logic [31:0] pick_operand(int kind);
      case (kind)
         0: return 32'h8000_0000;
         1: return 32'h7FFF_FFFF;
         2: return 32'hFFFF_FFFF;
         3: return 32'd0;
         default: return $urandom();
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      // idle state with all inputs at zero: R1 sum 0, R10 taken 0
      @(negedge clk);
      check("R1", result, 32'd0);
      check("R10", {31'd0, taken}, 32'd0);

      // directed corners
      apply(32'h7FFF_FFFF, 32'd1, 3'b000, 1'b0, 1'b1, 1'b0);   // R1 overflow wraps
      apply(32'hFFFF_FFFF, 32'd1, 3'b000, 1'b0, 1'b0, 1'b0);   // R1 carry dropped
      apply(32'd0, 32'd1, 3'b000, 1'b1, 1'b1, 1'b0);           // R2 subtract
      apply(32'd5, 32'd3, 3'b000, 1'b1, 1'b0, 1'b0);           // R2 immediate form adds
      check("R2", result, 32'd8);
      apply(32'hFFFF_FFFF, 32'd1, 3'b010, 1'b0, 1'b1, 1'b0);   // R3 -1 < 1
      apply(32'hFFFF_FFFF, 32'd1, 3'b011, 1'b0, 1'b1, 1'b0);   // R4 not below
      apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b010, 1'b0, 1'b1, 1'b0); // R3 overflow case
      apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b100, 1'b0, 1'b1, 1'b0); // R5 xor
      apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b110, 1'b0, 1'b1, 1'b0); // R5 or
      apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b111, 1'b0, 1'b1, 1'b0); // R5 and
      apply(32'h0000_0003, 32'hFFFF_FFE5, 3'b001, 1'b0, 1'b1, 1'b0); // R6 amount 5 only
      check("R6", result, 32'h0000_0060);
      apply(32'h8000_0000, 32'd31, 3'b101, 1'b1, 1'b1, 1'b0);  // R7 arith fill
      check("R7", result, 32'hFFFF_FFFF);
      apply(32'h8000_0000, 32'd31, 3'b101, 1'b0, 1'b0, 1'b0);  // R7 logical fill
      check("R7", result, 32'h0000_0001);
      apply(32'h1234_5678, 32'h1234_5678, 3'b000, 1'b0, 1'b1, 1'b1); // R8 equal
      apply(32'h1234_5678, 32'h1234_5678, 3'b001, 1'b0, 1'b1, 1'b1); // R8 not equal
      apply(32'h8000_0000, 32'd1, 3'b100, 1'b0, 1'b1, 1'b1);   // R8 signed lt
      apply(32'h8000_0000, 32'd1, 3'b111, 1'b0, 1'b1, 1'b1);   // R8 unsigned ge
      apply(32'd7, 32'd7, 3'b101, 1'b0, 1'b1, 1'b1);           // R8 ge on equal
      apply(32'd7, 32'd7, 3'b010, 1'b0, 1'b1, 1'b1);           // R9 reserved
      apply(32'd1, 32'd7, 3'b011, 1'b0, 1'b1, 1'b1);           // R9 reserved

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, b;
         a = pick_operand($urandom_range(0, 7));
         b = ($urandom_range(0, 3) == 0) ? a : pick_operand($urandom_range(0, 7));
         apply(a, b, 3'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule